// File: doc/BRIEF.md
# Address and Stack Fault Detector

This block sits beside the execution pipeline of a 16-bit processor core. On every cycle it inspects the memory access the core presents and any write to the stack pointer. When an access or stack-pointer value is illegal, it raises a trap request. A separate trap controller arbitrates these requests and takes the vector. The detector only classifies the faults.

Address faults fall into four cases:
- a word access to data space at an odd address;
- a data read beyond the implemented data RAM, or into the wrong operand space while the core runs dual-operand multiply-accumulate;
- a program-space read or instruction fetch beyond implemented program memory;
- an instruction fetch from the vector table.

Stack faults are raised when a new stack-pointer value is above the programmable limit, or below a fixed floor. The limit register lives inside the block and is written through its own strobe.

Every output is registered, so each fault shows up as a one-cycle pulse on the clock edge that samples the offending request. A 3-bit cause code travels with the pulses. The memory map is set by parameters.

Top module: `addr_stack_fault_det`

## Requirements
- R1: A word access (`acc_word`=1) of kind data read (`acc_kind`=2'b00) or data write (2'b01) at an odd address raises `addr_err` with cause 0. Byte accesses are never flagged for alignment.
- R2: Outside multiply-accumulate mode, a data read at an address at or above `DATA_END` raises `addr_err` with cause 1. Data writes are not checked against this bound.
- R3: A data read with `mac_mode`=1 is checked against the operand spaces, selected by `mac_y`. With `mac_y`=0 (X operand), an address at or above `XY_SPLIT` gives cause 1. With `mac_y`=1 (Y operand), an address below `XY_SPLIT` or at or above `DATA_END` gives cause 1.
- R4: A program-space data read (`acc_kind`=2'b11) at an address at or above `PROG_END` raises `addr_err` with cause 2.
- R5: An instruction fetch (`acc_kind`=2'b10) at an address from `VEC_LO` to `VEC_HI` inclusive raises `addr_err` with cause 3.
- R6: An instruction fetch at an address at or above `PROG_END` raises `addr_err` with cause 2. This covers literal branch targets and returns through a loaded stack.
- R7: A stack-pointer write (`sp_we`) with a value strictly greater than the limit register raises `stack_err` with cause 4. A limit write in the same cycle takes effect only for later stack-pointer writes.
- R8: A stack-pointer write with a value below `SP_FLOOR` (default 0x0800) raises `stack_err` with cause 5.
- R9: Reset sets the limit register to 0xFFFE. Until it is reprogrammed, only the value 0xFFFF overflows.
- R10: `addr_err` and `stack_err` are registered one cycle after the request and last one cycle. With `acc_valid` and `sp_we` both low, both are 0 and cause is 0 in the next cycle. Reset clears all outputs.
- R11: Both pulses may fire in the same cycle; cause then reports the stack fault. Overflow outranks underflow. Among address faults, the lowest cause code wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 00 data read, 01 data write, 10 instruction fetch, 11 program-space data read |
| acc_word | input | 1 | 1 word access, 0 byte access |
| acc_addr | input | 16 | Access address |
| mac_mode | input | 1 | Dual-operand multiply-accumulate mode |
| mac_y | input | 1 | In that mode, 1 if the read is the Y operand |
| sp_we | input | 1 | Stack pointer written this cycle |
| sp_wdata | input | 16 | New stack pointer value |
| lim_we | input | 1 | Stack limit register write strobe |
| lim_wdata | input | 16 | New stack limit value |
| addr_err | output | 1 | Address fault pulse |
| stack_err | output | 1 | Stack fault pulse |
| cause | output | 3 | Fault cause code, 0 when no fault |

## Verification
Every result is due on the first rising edge after the request: both fault pulses and the cause code leave one register stage. A changed stack limit is the exception; it first affects a stack-pointer write one edge after the limit write. The bench drives each request on a falling edge and waits for the next rising edge. It samples one time unit later, before the next request is driven. It then confirms the pulse has gone in the following idle cycle. Limit-register tests apply the limit write and the stack-pointer write either in the same cycle or in consecutive ones, so that both orderings are checked.

// File: rtl/addr_stack_fault_det.sv
module addr_stack_fault_det #(
  parameter int          AW        = 16,
  parameter logic [15:0] DATA_END  = 16'h0C00,
  parameter logic [15:0] XY_SPLIT  = 16'h0800,
  parameter logic [15:0] PROG_END  = 16'h2000,
  parameter logic [15:0] VEC_LO    = 16'h0004,
  parameter logic [15:0] VEC_HI    = 16'h00FF,
  parameter logic [15:0] SP_FLOOR  = 16'h0800,
  parameter logic [15:0] LIM_RESET = 16'hFFFE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [1:0]    acc_kind,
  input  logic          acc_word,
  input  logic [AW-1:0] acc_addr,
  input  logic          mac_mode,
  input  logic          mac_y,
  input  logic          sp_we,
  input  logic [AW-1:0] sp_wdata,
  input  logic          lim_we,
  input  logic [AW-1:0] lim_wdata,
  output logic          addr_err,
  output logic          stack_err,
  output logic [2:0]    cause
);

  localparam logic [AW-1:0] D_END = AW'(DATA_END);
  localparam logic [AW-1:0] XY    = AW'(XY_SPLIT);
  localparam logic [AW-1:0] P_END = AW'(PROG_END);
  localparam logic [AW-1:0] V_LO  = AW'(VEC_LO);
  localparam logic [AW-1:0] V_HI  = AW'(VEC_HI);
  localparam logic [AW-1:0] FLOOR = AW'(SP_FLOOR);
  localparam logic [AW-1:0] LIM0  = AW'(LIM_RESET);

  logic [AW-1:0] limit_q;

  wire is_dread = acc_valid && acc_kind == 2'b00;
  wire is_data  = acc_valid && !acc_kind[1];
  wire is_fetch = acc_valid && acc_kind == 2'b10;
  wire is_pread = acc_valid && acc_kind == 2'b11;

  wire out_x   = acc_addr >= XY;
  wire out_y   = acc_addr < XY || acc_addr >= D_END;
  wire out_d   = mac_mode ? (mac_y ? out_y : out_x) : (acc_addr >= D_END);

  wire f_mis   = is_data && acc_word && acc_addr[0];
  wire f_udata = is_dread && out_d;
  wire f_uprog = (is_pread || is_fetch) && acc_addr >= P_END;
  wire f_vec   = is_fetch && acc_addr >= V_LO && acc_addr <= V_HI;
  wire f_ovf   = sp_we && sp_wdata > limit_q;
  wire f_unf   = sp_we && sp_wdata < FLOOR;

  wire any_a = f_mis | f_udata | f_uprog | f_vec;
  wire any_s = f_ovf | f_unf;

  logic [2:0] cause_d;
  always_comb begin
    cause_d = 3'd0;
    if (f_ovf)        cause_d = 3'd4;
    else if (f_unf)   cause_d = 3'd5;
    else if (f_mis)   cause_d = 3'd0;
    else if (f_udata) cause_d = 3'd1;
    else if (f_uprog) cause_d = 3'd2;
    else if (f_vec)   cause_d = 3'd3;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q   <= LIM0;
      addr_err  <= 1'b0;
      stack_err <= 1'b0;
      cause     <= 3'd0;
    end else begin
      if (lim_we) limit_q <= lim_wdata;
      addr_err  <= any_a;
      stack_err <= any_s;
      cause     <= cause_d;
    end
  end

  assert_misalign_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_kind[1] && acc_word && acc_addr[0]) |=> addr_err);

  assert_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 2'b10 && acc_addr >= V_LO && acc_addr <= V_HI) |=> addr_err);

  assert_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_we && sp_wdata > limit_q) |=> (stack_err && cause == 3'd4));

  assert_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_we && sp_wdata < FLOOR && sp_wdata <= limit_q) |=> (stack_err && cause == 3'd5));

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !sp_we) |=> (!addr_err && !stack_err && cause == 3'd0));

  assert_stack_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err |-> cause[2]);

endmodule

// File: tb/addr_stack_fault_det_tb_top.sv
module addr_stack_fault_det_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_word = 1'b0, mac_mode = 1'b0, mac_y = 1'b0;
  logic [1:0] acc_kind = 2'b00;
  logic [15:0] acc_addr = '0, sp_wdata = '0, lim_wdata = '0;
  logic sp_we = 1'b0, lim_we = 1'b0;
  logic addr_err, stack_err;
  logic [2:0] cause;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  addr_stack_fault_det dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .acc_word(acc_word), .acc_addr(acc_addr), .mac_mode(mac_mode), .mac_y(mac_y),
    .sp_we(sp_we), .sp_wdata(sp_wdata), .lim_we(lim_we), .lim_wdata(lim_wdata),
    .addr_err(addr_err), .stack_err(stack_err), .cause(cause));

  // {req, kind, word, mac, macy, addr, spwe, sp, exp_a, exp_s, exp_cause}
  localparam int NV = 32;
  localparam logic [46:0] VEC [NV] = '{
    {4'd1, 2'b00, 3'b100, 16'h0101, 1'b0, 16'h0000, 5'b10_000}, // R1 odd word read
    {4'd1, 2'b01, 3'b100, 16'h0203, 1'b0, 16'h0000, 5'b10_000}, // R1 odd word write
    {4'd1, 2'b00, 3'b000, 16'h0101, 1'b0, 16'h0000, 5'b00_000}, // R1 byte ok
    {4'd1, 2'b10, 3'b100, 16'h0301, 1'b0, 16'h0000, 5'b00_000}, // R1 fetch not aligned-checked
    {4'd2, 2'b00, 3'b100, 16'h0C00, 1'b0, 16'h0000, 5'b10_001}, // R2 beyond RAM
    {4'd2, 2'b00, 3'b000, 16'h0BFF, 1'b0, 16'h0000, 5'b00_000}, // R2 last byte
    {4'd2, 2'b01, 3'b100, 16'h0C00, 1'b0, 16'h0000, 5'b00_000}, // R2 write unchecked
    {4'd3, 2'b00, 3'b110, 16'h0800, 1'b0, 16'h0000, 5'b10_001}, // R3 X in Y
    {4'd3, 2'b00, 3'b110, 16'h07FE, 1'b0, 16'h0000, 5'b00_000}, // R3 X ok
    {4'd3, 2'b00, 3'b111, 16'h07FE, 1'b0, 16'h0000, 5'b10_001}, // R3 Y in X
    {4'd3, 2'b00, 3'b111, 16'h0800, 1'b0, 16'h0000, 5'b00_000}, // R3 Y ok
    {4'd3, 2'b00, 3'b111, 16'h0C00, 1'b0, 16'h0000, 5'b10_001}, // R3 Y beyond RAM
    {4'd4, 2'b11, 3'b100, 16'h2000, 1'b0, 16'h0000, 5'b10_010}, // R4 prog read out
    {4'd4, 2'b11, 3'b100, 16'h1FFE, 1'b0, 16'h0000, 5'b00_000}, // R4 prog read ok
    {4'd5, 2'b10, 3'b100, 16'h0004, 1'b0, 16'h0000, 5'b10_011}, // R5 low edge
    {4'd5, 2'b10, 3'b100, 16'h00FF, 1'b0, 16'h0000, 5'b10_011}, // R5 high edge
    {4'd5, 2'b10, 3'b100, 16'h0100, 1'b0, 16'h0000, 5'b00_000}, // R5 above
    {4'd5, 2'b10, 3'b100, 16'h0002, 1'b0, 16'h0000, 5'b00_000}, // R5 below
    {4'd5, 2'b00, 3'b100, 16'h0004, 1'b0, 16'h0000, 5'b00_000}, // R5 data read of vector ok
    {4'd6, 2'b10, 3'b100, 16'h2000, 1'b0, 16'h0000, 5'b10_010}, // R6 branch target
    {4'd6, 2'b10, 3'b100, 16'hFFFE, 1'b0, 16'h0000, 5'b10_010}, // R6 return target
    {4'd6, 2'b10, 3'b100, 16'h1FFE, 1'b0, 16'h0000, 5'b00_000}, // R6 last word
    {4'd8, 2'b01, 3'b000, 16'h0000, 1'b1, 16'h07FE, 5'b01_101}, // R8 underflow
    {4'd8, 2'b01, 3'b000, 16'h0000, 1'b1, 16'h0800, 5'b00_000}, // R8 floor ok
    {4'd9, 2'b01, 3'b000, 16'h0000, 1'b1, 16'hFFFE, 5'b00_000}, // R9 reset limit
    {4'd9, 2'b01, 3'b000, 16'h0000, 1'b1, 16'hFFFF, 5'b01_100}, // R9 only FFFF
    {4'd11, 2'b00, 3'b100, 16'h0C01, 1'b0, 16'h0000, 5'b10_000}, // R11 mis beats udata
    {4'd11, 2'b00, 3'b100, 16'h0C01, 1'b1, 16'h0001, 5'b11_101}, // R11 both, stack cause
    {4'd11, 2'b10, 3'b100, 16'h0010, 1'b1, 16'h0900, 5'b10_011}, // R11 addr only
    {4'd11, 2'b11, 3'b100, 16'h3001, 1'b0, 16'h0000, 5'b10_010}, // R11 prog odd
    {4'd11, 2'b10, 3'b100, 16'hFFFF, 1'b1, 16'hFFFF, 5'b11_100}, // R11 overflow cause
    {4'd10, 2'b00, 3'b000, 16'h0000, 1'b0, 16'h0000, 5'b00_000}  // R10 plain read
  };

  task automatic check(input int req, input logic ea, input logic es, input logic [2:0] ec);
    checks++;
    if (addr_err !== ea || stack_err !== es || cause !== ec) begin
      errors++;
      $display("FAIL R%0d: got a=%b s=%b c=%0d expected a=%b s=%b c=%0d",
               req, addr_err, stack_err, cause, ea, es, ec);
    end
  endtask

  task automatic idle();
    acc_valid = 1'b0; sp_we = 1'b0; lim_we = 1'b0; mac_mode = 1'b0; mac_y = 1'b0;
  endtask

  task automatic step();
    @(posedge clk); #1;
    @(negedge clk);
  endtask

  task automatic sp_write(input logic [15:0] v);
    @(negedge clk); idle(); sp_we = 1'b1; sp_wdata = v;
    @(posedge clk); #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #3;
    check(10, 1'b0, 1'b0, 3'd0); // R10 reset state
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      acc_valid = 1'b1;
      {acc_kind, acc_word, mac_mode, mac_y, acc_addr, sp_we, sp_wdata} = VEC[i][42:5];
      @(posedge clk); #1;
      check(int'(VEC[i][46:43]), VEC[i][4], VEC[i][3], VEC[i][2:0]);
    end
    // R10 pulse clears, valid low ignores misaligned access
    @(negedge clk); idle(); acc_kind = 2'b00; acc_word = 1'b1; acc_addr = 16'h0101;
    @(posedge clk); #1; check(10, 1'b0, 1'b0, 3'd0);
    @(negedge clk); acc_valid = 1'b1;
    @(posedge clk); #1; check(10, 1'b1, 1'b0, 3'd0);
    @(negedge clk); idle();
    @(posedge clk); #1; check(10, 1'b0, 1'b0, 3'd0);
    // R7 programmed limit
    @(negedge clk); idle(); lim_we = 1'b1; lim_wdata = 16'h0900;
    @(posedge clk); #1;
    sp_write(16'h0902); check(7, 1'b0, 1'b1, 3'd4);
    sp_write(16'h0900); check(7, 1'b0, 1'b0, 3'd0);
    // R7 same-cycle limit write uses old limit
    @(negedge clk); idle(); lim_we = 1'b1; lim_wdata = 16'h0A00; sp_we = 1'b1; sp_wdata = 16'h0950;
    @(posedge clk); #1; check(7, 1'b0, 1'b1, 3'd4);
    sp_write(16'h0950); check(7, 1'b0, 1'b0, 3'd0);
    sp_write(16'h0A02); check(7, 1'b0, 1'b1, 3'd4);
    // R11 limit below floor: overflow beats underflow
    @(negedge clk); idle(); lim_we = 1'b1; lim_wdata = 16'h0700;
    @(posedge clk); #1;
    sp_write(16'h0780); check(11, 1'b0, 1'b1, 3'd4);
    // R9 reset restores limit
    @(negedge clk); idle(); rst_n = 1'b0;
    #1; check(9, 1'b0, 1'b0, 3'd0);
    @(negedge clk); rst_n = 1'b1;
    sp_write(16'h0A00); check(9, 1'b0, 1'b0, 3'd0);
    sp_write(16'hFFFF); check(9, 1'b0, 1'b1, 3'd4);
    @(negedge clk); idle();
    @(posedge clk); #1; check(10, 1'b0, 1'b0, 3'd0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule